// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization

This block divides every nominal bit on a CAN bus into time quanta and chooses the point at which the receive line is read. It is clocked by the system clock and moves forward one quantum for each single-cycle pulse on `tq_en`. That pulse comes from a prescaler outside the block. Each bit begins with a one-quantum sync segment. Next comes a first segment, which holds both the propagation time and phase 1, and the bit ends with a second segment (phase 2). The two segment lengths and the jump width are programmed as length minus one. Settings that are not legal are forced up to the nearest legal value.

While the frame logic reports an idle bus, the first edge that qualifies restarts the bit, which is a hard synchronization. During a frame, an edge that falls inside a segment moves the sample point. An edge in the first segment makes that segment longer. An edge in the second segment makes it shorter. Either correction is capped at the jump width, and only one correction is allowed per sample interval. The block outputs three signals: the voted bit, a strobe at the sample point, and a strobe at the end of the sync segment, which tells the transmitter when to drive the next bit. The bit can be read from one sample or voted from three. Synchronization can follow only falling (recessive-to-dominant) edges or edges in both directions.

Top module: `can_bit_timing`

## Requirements
- R1: With no edges seen, a bit lasts 3 + `cfg_tseg1` + `cfg_tseg2` quanta: one sync quantum, then `cfg_tseg1`+1 quanta, then `cfg_tseg2`+1 quanta. `tx_stb` pulses for one clock, on the clock after the `tq_en` that ends the sync quantum. `sample_stb` pulses for one clock, on the clock after the `tq_en` that ends the first segment.
- R2: A `cfg_tseg1` value of 0 or 1 acts as 2, so the first segment always lasts at least 3 quanta.
- R3: A `cfg_tseg2` value of 0 acts as 1. In triple sampling mode, values 0 and 1 both act as 2.
- R4: The jump width is `cfg_sjw`+1 quanta, reduced where needed so that it does not exceed the effective length of either segment.
- R5: An edge seen on the quantum that lies k quanta after the sync quantum, while the first segment is running, makes the first segment longer by min(k, jump width).
- R6: An edge seen on quantum c (counting from 0) of the second segment has a phase error of (second segment length − c). If that error is no more than the jump width, the edge quantum becomes the sync quantum of the next bit. Otherwise the second segment becomes shorter by the jump width.
- R7: At most one resynchronization happens between two sample points, and a hard synchronization counts as that one. An edge inside the sync quantum causes no correction.
- R8: While `bus_idle` is 1, a qualifying edge causes a hard synchronization. The edge quantum becomes the sync quantum, `tx_stb` pulses, and the next sample comes `cfg_tseg1`+1 quanta later.
- R9: With `cfg_triple` = 0, `rx_bit` takes the `rx` value at the sample quantum. With `cfg_triple` = 1, `rx_bit` takes the majority of `rx` over the last three quanta of the first segment. `rx_bit` only changes when `sample_stb` pulses.
- R10: An edge is a difference between `rx` at the current `tq_en` and `rx` at the previous one, where `rx` = 1 is recessive. The starting value after reset is 1. When `cfg_both_edges` = 0, only a change from 1 to 0 counts. When `cfg_both_edges` = 1, both directions count.
- R11: Reset is synchronous and active high. It clears the held configuration to zero, sets `rx_bit` to 1, clears both strobes, and places the block at the start of a sync quantum. Clocks without `tq_en` change no output and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_en | input | 1 | One-cycle pulse, one per time quantum |
| rx | input | 1 | Receive line, already synchronized (1 = recessive) |
| bus_idle | input | 1 | Bus idle, so the next edge causes a hard synchronization |
| cfg_tseg1 | input | 4 | First segment length minus one |
| cfg_tseg2 | input | 3 | Second segment length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | 1 = three-sample majority, 0 = single sample |
| cfg_both_edges | input | 1 | 1 = synchronize on both edges, 0 = falling edges only |
| rx_bit | output | 1 | Voted bit value, updated at the sample point |
| sample_stb | output | 1 | One-clock strobe at the sample point |
| tx_stb | output | 1 | One-clock strobe at the end of the sync quantum |

## Verification
The assertions assume that the configuration inputs change only while reset is held. The segment-bound checks and the cap checks compare the stored extension and the stored shortening against the effective lengths in force now, and a change in the middle of a bit would break that comparison. They also assume that `rx` is already synchronized to `clk` and that `tq_en` is a single-cycle pulse. The stimulus follows these rules: it sets every configuration while reset is asserted, drives `rx` and `tq_en` only on falling clock edges, and holds `rx` at recessive through each reset so that the stored previous value agrees with the line.

// File: rtl/can_btl_pkg.sv
package can_btl_pkg;

    localparam int TS1_W = 4;
    localparam int TS2_W = 3;
    localparam int SJW_W = 2;
    localparam int MAX_SEG1 = (1 << TS1_W);
    localparam int MAX_SJW  = (1 << SJW_W);
    localparam int CNT_W = $clog2(MAX_SEG1 + MAX_SJW) + 1;

    typedef logic [CNT_W-1:0] qcnt_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [TS1_W-1:0] tseg1;
        logic [TS2_W-1:0] tseg2;
        logic [SJW_W-1:0] sjw;
        logic             triple;
        logic             both_edges;
    } cfg_t;

    typedef struct packed {
        qcnt_t len1;
        qcnt_t len2;
        qcnt_t sjw;
        logic  triple;
        logic  both_edges;
    } timing_t;

    typedef struct packed {
        seg_e  seg;
        qcnt_t cnt;
        qcnt_t ext;
        qcnt_t shrink;
        logic  rdone;
    } bt_state_t;

    function automatic qcnt_t qmin(qcnt_t a, qcnt_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic maj3(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Turn raw length-minus-one fields into legal quantum counts.
    function automatic timing_t legalize(cfg_t c);
        timing_t t;
        qcnt_t   l1;
        qcnt_t   l2;
        qcnt_t   lo2;
        qcnt_t   j;
        l1  = qcnt_t'(c.tseg1) + qcnt_t'(1);
        if (l1 < qcnt_t'(3)) l1 = qcnt_t'(3);
        lo2 = c.triple ? qcnt_t'(3) : qcnt_t'(2);
        l2  = qcnt_t'(c.tseg2) + qcnt_t'(1);
        if (l2 < lo2) l2 = lo2;
        j = qcnt_t'(c.sjw) + qcnt_t'(1);
        j = qmin(j, l1);
        j = qmin(j, l2);
        t.len1       = l1;
        t.len2       = l2;
        t.sjw        = j;
        t.triple     = c.triple;
        t.both_edges = c.both_edges;
        return t;
    endfunction

endpackage

// File: rtl/btl_cfg_reg.sv
module btl_cfg_reg
    import can_btl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_t    cfg_in,
    output timing_t tm
);

    cfg_t held;

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= cfg_in;
    end

    assign tm = legalize(held);

    // R2: first segment never shorter than three quanta
    p_seg1_floor_r2: assert property (@(posedge clk) disable iff (rst)
        tm.len1 >= qcnt_t'(3) && tm.len1 <= qcnt_t'(MAX_SEG1));

    // R3: second segment floor depends on sampling mode
    p_seg2_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (held.triple |-> tm.len2 >= qcnt_t'(3)) and (tm.len2 >= qcnt_t'(2)));

    // R4: jump width bounded by both segments
    p_sjw_cap_r4: assert property (@(posedge clk) disable iff (rst)
        tm.sjw != '0 && tm.sjw <= tm.len1 && tm.sjw <= tm.len2);

endmodule

// File: rtl/btl_edge_vote.sv
module btl_edge_vote
    import can_btl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tq_en,
    input  logic rx,
    input  logic both_edges,
    input  logic triple,
    input  logic shift_en,
    output logic edge_o,
    output logic voted
);

    logic       prev_rx;
    logic [1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rx <= 1'b1;
        end else if (tq_en) begin
            prev_rx <= rx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= 2'b11;
        end else if (shift_en) begin
            hist <= {hist[0], rx};
        end
    end

    always_comb begin
        if (both_edges) edge_o = tq_en & (prev_rx ^ rx);
        else            edge_o = tq_en & prev_rx & ~rx;
    end

    assign voted = triple ? maj3(hist[1], hist[0], rx) : rx;

    // R10: in falling-only mode an edge always lands on a dominant level
    p_fall_only_r10: assert property (@(posedge clk) disable iff (rst)
        (edge_o && !both_edges) |-> !rx);

    // R10: no edge reported without a quantum pulse
    p_edge_needs_tq_r10: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> tq_en);

endmodule

// File: rtl/btl_seg_fsm.sv
module btl_seg_fsm
    import can_btl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tq_en,
    input  logic    edge_i,
    input  logic    bus_idle,
    input  timing_t tm,
    input  logic    voted,
    output logic    shift_en,
    output logic    rx_bit,
    output logic    sample_stb,
    output logic    tx_stb
);

    bt_state_t st;
    bt_state_t nx;
    logic      smp;
    logic      txp;
    qcnt_t     seg1_last;
    qcnt_t     seg2_last;
    qcnt_t     late_fix;
    qcnt_t     early_err;
    qcnt_t     early_last;

    assign seg1_last  = tm.len1 + st.ext - qcnt_t'(1);
    assign seg2_last  = tm.len2 - st.shrink - qcnt_t'(1);
    assign late_fix   = qmin(st.cnt + qcnt_t'(1), tm.sjw);
    assign early_err  = tm.len2 - st.cnt;
    assign early_last = tm.len2 - tm.sjw - qcnt_t'(1);

    always_comb begin
        nx       = st;
        smp      = 1'b0;
        txp      = 1'b0;
        shift_en = 1'b0;
        if (tq_en) begin
            if (bus_idle && edge_i) begin
                nx.seg    = SEG_ONE;
                nx.cnt    = '0;
                nx.ext    = '0;
                nx.shrink = '0;
                nx.rdone  = 1'b1;
                txp       = 1'b1;
            end else begin
                unique case (st.seg)
                    SEG_SYNC: begin
                        nx.seg = SEG_ONE;
                        nx.cnt = '0;
                        txp    = 1'b1;
                    end
                    SEG_ONE: begin
                        if (edge_i && !st.rdone) begin
                            nx.ext   = late_fix;
                            nx.rdone = 1'b1;
                            nx.cnt   = st.cnt + qcnt_t'(1);
                            shift_en = 1'b1;
                        end else if (st.cnt == seg1_last) begin
                            smp      = 1'b1;
                            nx.seg   = SEG_TWO;
                            nx.cnt   = '0;
                            nx.ext   = '0;
                            nx.rdone = 1'b0;
                        end else begin
                            nx.cnt   = st.cnt + qcnt_t'(1);
                            shift_en = 1'b1;
                        end
                    end
                    SEG_TWO: begin
                        if (edge_i && !st.rdone) begin
                            nx.rdone = 1'b1;
                            if (early_err <= tm.sjw) begin
                                nx.seg    = SEG_ONE;
                                nx.cnt    = '0;
                                nx.shrink = '0;
                                txp       = 1'b1;
                            end else if (st.cnt >= early_last) begin
                                nx.seg    = SEG_SYNC;
                                nx.cnt    = '0;
                                nx.shrink = '0;
                            end else begin
                                nx.shrink = tm.sjw;
                                nx.cnt    = st.cnt + qcnt_t'(1);
                            end
                        end else if (st.cnt == seg2_last) begin
                            nx.seg    = SEG_SYNC;
                            nx.cnt    = '0;
                            nx.shrink = '0;
                        end else begin
                            nx.cnt = st.cnt + qcnt_t'(1);
                        end
                    end
                    default: begin
                        nx.seg = SEG_SYNC;
                        nx.cnt = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.seg     <= SEG_SYNC;
            st.cnt     <= '0;
            st.ext     <= '0;
            st.shrink  <= '0;
            st.rdone   <= 1'b0;
            rx_bit     <= 1'b1;
            sample_stb <= 1'b0;
            tx_stb     <= 1'b0;
        end else begin
            st         <= nx;
            sample_stb <= smp;
            tx_stb     <= txp;
            if (smp) rx_bit <= voted;
        end
    end

    // R1: the two strobes mark different quanta
    p_strobe_apart_r1: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && tx_stb));

    // R11: strobes only follow a quantum pulse
    p_strobe_after_tq_r11: assert property (@(posedge clk) disable iff (rst)
        (sample_stb || tx_stb) |-> $past(tq_en));

    // R9: sampled bit only moves on a sample strobe
    p_bit_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |-> $stable(rx_bit));

    // R5: lengthening never exceeds the jump width
    p_ext_cap_r5: assert property (@(posedge clk) disable iff (rst)
        st.ext <= tm.sjw);

    // R6: shortening never exceeds the jump width
    p_shrink_cap_r6: assert property (@(posedge clk) disable iff (rst)
        st.shrink <= tm.sjw);

    // R7: the one-resync lock releases only at a sample point
    p_lock_release_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(st.rdone) |-> sample_stb);

    // R8: an idle-bus edge restarts the bit at once
    p_hard_sync_r8: assert property (@(posedge clk) disable iff (rst)
        (tq_en && bus_idle && edge_i) |=> (tx_stb && st.seg == SEG_ONE && st.cnt == '0));

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_btl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tq_en,
    input  logic             rx,
    input  logic             bus_idle,
    input  logic [TS1_W-1:0] cfg_tseg1,
    input  logic [TS2_W-1:0] cfg_tseg2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             cfg_triple,
    input  logic             cfg_both_edges,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             tx_stb
);

    cfg_t    cfg_in;
    timing_t tm;
    logic    edge_w;
    logic    voted_w;
    logic    shift_w;

    assign cfg_in = {cfg_tseg1, cfg_tseg2, cfg_sjw, cfg_triple, cfg_both_edges};

    btl_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .tm     (tm)
    );

    btl_edge_vote u_edge (
        .clk        (clk),
        .rst        (rst),
        .tq_en      (tq_en),
        .rx         (rx),
        .both_edges (tm.both_edges),
        .triple     (tm.triple),
        .shift_en   (shift_w),
        .edge_o     (edge_w),
        .voted      (voted_w)
    );

    btl_seg_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tq_en      (tq_en),
        .edge_i     (edge_w),
        .bus_idle   (bus_idle),
        .tm         (tm),
        .voted      (voted_w),
        .shift_en   (shift_w),
        .rx_bit     (rx_bit),
        .sample_stb (sample_stb),
        .tx_stb     (tx_stb)
    );

endmodule

// File: tb/sim_can_bit_timing.sv
module sim_can_bit_timing;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tq_en = 1'b0;
    logic       rx = 1'b1;
    logic       bus_idle = 1'b0;
    logic [3:0] cfg_tseg1 = '0;
    logic [2:0] cfg_tseg2 = '0;
    logic [1:0] cfg_sjw = '0;
    logic       cfg_triple = 1'b0;
    logic       cfg_both_edges = 1'b0;
    logic       rx_bit;
    logic       sample_stb;
    logic       tx_stb;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R11";
    bit    chk_on = 0;
    bit    done = 0;

    can_bit_timing u0 (
        .clk            (clk),
        .rst            (rst),
        .tq_en          (tq_en),
        .rx             (rx),
        .bus_idle       (bus_idle),
        .cfg_tseg1      (cfg_tseg1),
        .cfg_tseg2      (cfg_tseg2),
        .cfg_sjw        (cfg_sjw),
        .cfg_triple     (cfg_triple),
        .cfg_both_edges (cfg_both_edges),
        .rx_bit         (rx_bit),
        .sample_stb     (sample_stb),
        .tx_stb         (tx_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: position in the bit counted from the sync quantum.
    int   m_t, m_ext, m_shr, l1, l2, sj, t2, sp, tot, c, e;
    logic m_rd, m_prev, h0, h1, edg;
    logic e_bit, e_smp, e_tx;

    always @(posedge clk) begin
        l1 = (cfg_tseg1 < 2) ? 3 : int'(cfg_tseg1) + 1;
        t2 = int'(cfg_tseg2);
        if (t2 < 1) t2 = 1;
        if (cfg_triple && t2 < 2) t2 = 2;
        l2 = t2 + 1;
        sj = int'(cfg_sjw) + 1;
        if (sj > l2) sj = l2;
        if (sj > l1) sj = l1;
        e_smp = 0;
        e_tx  = 0;
        if (rst) begin
            m_t = 0; m_ext = 0; m_shr = 0; m_rd = 0; m_prev = 1;
            h0 = 1; h1 = 1; e_bit = 1;
        end else if (tq_en) begin
            edg = cfg_both_edges ? (m_prev != rx) : (m_prev && !rx);
            m_prev = rx;
            sp  = l1 + m_ext;
            tot = 1 + l1 + m_ext + l2 - m_shr;
            if (bus_idle && edg) begin
                m_t = 1; m_ext = 0; m_shr = 0; m_rd = 1; e_tx = 1;
            end else if (m_t == 0) begin
                m_t = 1; e_tx = 1;
            end else if (m_t <= sp) begin
                if (edg && !m_rd) begin
                    m_ext = (m_t < sj) ? m_t : sj;
                    m_rd = 1; h1 = h0; h0 = rx; m_t = m_t + 1;
                end else if (m_t == sp) begin
                    e_bit = cfg_triple ? ((h1 & h0) | (h1 & rx) | (h0 & rx)) : rx;
                    e_smp = 1; m_rd = 0; m_t = m_t + 1;
                end else begin
                    h1 = h0; h0 = rx; m_t = m_t + 1;
                end
            end else begin
                c = m_t - sp - 1;
                if (edg && !m_rd) begin
                    m_rd = 1;
                    e = l2 - c;
                    if (e <= sj) begin
                        m_t = 1; m_ext = 0; m_shr = 0; e_tx = 1;
                    end else begin
                        m_shr = sj;
                        if (m_t >= sp + l2 - sj) begin
                            m_t = 0; m_ext = 0; m_shr = 0;
                        end else m_t = m_t + 1;
                    end
                end else if (m_t == tot - 1) begin
                    m_t = 0; m_ext = 0; m_shr = 0;
                end else m_t = m_t + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            vectors++;
            if ({rx_bit, sample_stb, tx_stb} !== {e_bit, e_smp, e_tx}) begin
                fails++;
                $display("FAIL %s t=%0t act bit/smp/tx=%b%b%b exp=%b%b%b",
                         cur_req, $time, rx_bit, sample_stb, tx_stb, e_bit, e_smp, e_tx);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int t1, input int t2v, input int sjv, input bit tri3, input bit both);
        @(negedge clk);
        rst = 1; tq_en = 0; rx = 1; bus_idle = 0;
        cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2v); cfg_sjw = 2'(sjv);
        cfg_triple = tri3; cfg_both_edges = both;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    logic seen_smp, seen_tx;

    task automatic tick(input logic r, input int gap);
        @(negedge clk);
        rx = r; tq_en = 1;
        @(negedge clk);
        tq_en = 0;
        seen_smp = sample_stb;
        seen_tx  = tx_stb;
        repeat (gap) @(negedge clk);
    endtask

    // Measure sample-to-sample spacing in quanta with a quiet recessive bus.
    task automatic spacing(input int exp, input string req);
        int last = -1;
        for (int q = 0; q < 4 * exp; q++) begin
            tick(1'b1, 0);
            if (seen_smp) begin
                if (last >= 0) chk((q - last) == exp, req, q - last, exp);
                last = q;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog act=running exp=finished");
            finish_run();
        end
    end

    logic [15:0] lf = 16'hACE1;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        do_reset(4, 2, 0, 0, 0);
        chk_on = 1;
        // R11: reset values
        cur_req = "R11";
        chk(rx_bit === 1'b1, "R11 rx_bit after reset", int'(rx_bit), 1);
        chk(sample_stb === 1'b0 && tx_stb === 1'b0, "R11 strobes after reset",
            int'({sample_stb, tx_stb}), 0);

        // R1: nominal bit length
        cur_req = "R1";
        spacing(9, "R1 bit length 4/2");
        do_reset(15, 7, 3, 0, 0);
        spacing(25, "R1 bit length 15/7");

        // R2: short first segment forced up
        cur_req = "R2";
        do_reset(1, 2, 0, 0, 0);
        spacing(7, "R2 tseg1=1");
        do_reset(0, 2, 0, 0, 0);
        spacing(7, "R2 tseg1=0");

        // R3: second segment floors
        cur_req = "R3";
        do_reset(4, 0, 0, 0, 0);
        spacing(8, "R3 tseg2=0 single");
        do_reset(4, 1, 0, 1, 0);
        spacing(9, "R3 tseg2=1 triple");

        // R11: idle clocks between quanta change nothing
        cur_req = "R11";
        do_reset(3, 2, 1, 0, 1);
        for (int q = 0; q < 30; q++) tick(q % 5 < 2, 3);

        // R8: hard sync on idle bus
        cur_req = "R8";
        do_reset(6, 5, 1, 0, 0);
        bus_idle = 1;
        for (int q = 0; q < 4; q++) tick(1'b1, 0);
        tick(1'b0, 0);
        chk(seen_tx === 1'b1, "R8 tx strobe on idle edge", int'(seen_tx), 1);
        bus_idle = 0;
        for (int q = 0; q < 6; q++) begin
            tick(1'b0, 0);
            chk(seen_smp === 1'b0, "R8 no early sample", int'(seen_smp), 0);
        end
        tick(1'b0, 0);
        chk(seen_smp === 1'b1, "R8 sample after tseg1+1", int'(seen_smp), 1);
        chk(rx_bit === 1'b0, "R8 sampled dominant", int'(rx_bit), 0);

        // R5 / R6 / R4: single edge at every position of the bit
        for (int sjv = 0; sjv < 4; sjv++) begin
            for (int k = 1; k <= 14; k++) begin
                cur_req = (k <= 7) ? "R5" : "R6";
                do_reset(6, 5, sjv, 0, 0);
                for (int q = 0; q < k; q++) tick(1'b1, 0);
                for (int q = 0; q < 30; q++) tick(1'b0, 0);
            end
        end
        cur_req = "R4";
        for (int k = 1; k <= 6; k++) begin
            do_reset(2, 1, 3, 0, 1);
            for (int q = 0; q < k; q++) tick(1'b1, 0);
            for (int q = 0; q < 6; q++) tick(1'b0, 0);
            for (int q = 0; q < 12; q++) tick(q % 3 == 0, 0);
        end

        // R7: dense toggling, at most one correction per sample interval
        cur_req = "R7";
        do_reset(7, 4, 2, 0, 1);
        for (int q = 0; q < 80; q++) tick((q / 2) % 2 == 0, 0);

        // R10: rising edges ignored in falling-only mode, used in both-edge mode
        cur_req = "R10";
        for (int both = 0; both < 2; both++) begin
            do_reset(5, 3, 1, 0, both[0]);
            for (int q = 0; q < 60; q++) tick((q % 7) < 3, 0);
        end

        // R9: sampling modes under pseudo-random traffic and configs
        cur_req = "R9";
        for (int run = 0; run < 40; run++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_reset(int'(lf[3:0]), int'(lf[6:4]), int'(lf[8:7]), lf[9], lf[10]);
            for (int q = 0; q < 70; q++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                bus_idle = (lf[7:4] == 4'h0);
                tick(lf[0] | lf[1], int'(lf[3:2]) % 2);
            end
        end

        finish_run();
    end

endmodule